// File: doc/BRIEF.md
# GF(2) Inversion-Polynomial Solver

This engine finds the set of inverted stage couplings, written as a polynomial D(X), that makes a mixed-inversion signature register end on a chosen signature. It takes a target polynomial A(X), a response length L, the low K coefficients of a monic degree-K feedback polynomial C(X), and a flag for whether the first stage carries an extra inverter. The all-ones polynomial B(X) of degree L (which equals (X^(L+1)+1)/(X+1)) is folded modulo C. A shift-subtract extended Euclid then finds G = gcd(B, C) and a coefficient u with u*B = G (mod C). The target is divided by G, and the quotient times u, reduced modulo C, is returned as D.

When the inverter flag is set, the target is first adjusted by F(X) mod C, where F is the all-ones polynomial of degree L-1. If G does not divide the (adjusted) target, no D exists. The engine then reports that one extra dummy response pattern is needed. A request enters through a valid/ready port and the answer leaves through a valid/ready port. The engine takes one request at a time.

Top module: `invpoly_solver`

## Requirements
- R1: After reset, req_ready is 1 and res_valid is 0.
- R2: With target 4'b1101 (X^3+X^2+1), L=10, req_char 4'b1001 (C = X^4+X^3+1) and req_inv0=0, the result is res_d = 4'b0101 (X^2+1) and res_nosol = 0. Bit i of every polynomial field is the coefficient of X^i.
- R3: With req_inv0=0 and res_nosol=0, the returned D satisfies D*B mod C = A.
- R4: With req_inv0=1 and res_nosol=0, the returned D satisfies (D*B + F) mod C = A.
- R5: res_nosol is 1 exactly when no D of degree below K satisfies the equation of R3 or R4. When it is 1, res_d is 0.
- R6: For a primitive C, a length L that has no solution is followed by a length L+1 that has one.
- R7: A request is taken on a clock edge where req_valid and req_ready are both 1. After that, req_ready stays 0 until the result has been taken, and req_valid during that time has no effect on the result. req_ready and res_valid are never 1 together.
- R8: While res_valid is 1 and res_ready is 0, res_valid, res_d and res_nosol hold their values.
- R9: res_valid rises at most L + 6K + 13 cycles after the accepting edge.

Preconditions: bit 0 of req_char must be 1, and K must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_target | input | K | Target polynomial A |
| req_len | input | LW | Response length L |
| req_char | input | K | Coefficients X^0..X^(K-1) of C; the X^K term is implied |
| req_inv0 | input | 1 | First-stage inverter present |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_d | output | K | Inversion polynomial D |
| res_nosol | output | 1 | No D exists; a dummy pattern is needed |

## Verification
The hardest outcome to reach is the no-solution outcome. It needs a GCD other than 1 together with a target that is not a multiple of that GCD. With a primitive C this only happens when L+1 is a multiple of the period of C, because B then folds to zero. The stimulus therefore sweeps L across a whole period (0 to 15 for degree 4) with every target and both inverter settings. It also adds a non-primitive C = X^4+1, whose repeated factor makes many GCDs other than 1. Back-pressure of varying length and stray requests during busy periods are mixed into the same sweep.

// File: rtl/invpoly_pkg.sv
package invpoly_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ONES,
    PH_GCD,
    PH_DIV,
    PH_MUL,
    PH_OUT
  } phase_t;

  // index of highest set bit, -1 for the zero vector
  function automatic int top_bit(input logic [63:0] v);
    int r;
    r = -1;
    for (int i = 0; i < 64; i++) if (v[i]) r = i;
    return r;
  endfunction

endpackage

// File: rtl/ones_mod_reducer.sv
// Folds the all-ones polynomials of degree L and L-1 modulo C, one term per clock.
module ones_mod_reducer #(
  parameter int K  = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic [K-1:0]  chr,
  output logic          done,
  output logic [K-1:0]  bm,
  output logic [K-1:0]  fm
);
  logic          run;
  logic [LW-1:0] cnt;
  logic [K-1:0]  r;
  logic [K-1:0]  r_nxt;

  always_comb begin
    r_nxt = {r[K-2:0], 1'b1} ^ (r[K-1] ? chr : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      r    <= '0;
      fm   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1;
        cnt <= '0;
        r   <= '0;
        fm  <= '0;
      end else if (run) begin
        r   <= r_nxt;
        cnt <= cnt + 1'b1;
        if (cnt == len) begin
          fm   <= r;
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign bm = r;

  assert_fold_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= len);
endmodule

// File: rtl/binary_xgcd.sv
// Shift-subtract extended Euclid; coef*bin == gcd (mod C) on completion.
module binary_xgcd import invpoly_pkg::*; #(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] bin,
  input  logic [K-1:0] chr,
  output logic         done,
  output logic [K:0]   gcd,
  output logic [K-1:0] coef
);
  logic         run;
  logic [K:0]   a, b;
  logic [K-1:0] ua, ub;
  logic [K:0]   cfull;
  logic [K:0]   ua_odd;
  logic [K-1:0] ua_half;
  int           da, db;

  always_comb begin
    cfull   = {1'b1, chr};
    ua_odd  = cfull ^ {1'b0, ua};
    ua_half = ua[0] ? ua_odd[K:1] : {1'b0, ua[K-1:1]};
    da      = top_bit(64'(a));
    db      = top_bit(64'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
      a    <= '0;
      b    <= '0;
      ua   <= '0;
      ub   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1;
        a   <= {1'b0, bin};
        b   <= {1'b1, chr};
        ua  <= {{(K-1){1'b0}}, 1'b1};
        ub  <= '0;
      end else if (run) begin
        if (a == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else if (!a[0]) begin
          a  <= {1'b0, a[K:1]};
          ua <= ua_half;
        end else if (da < db) begin
          a  <= a ^ b;
          b  <= a;
          ua <= ua ^ ub;
          ub <= ua;
        end else begin
          a  <= a ^ b;
          ua <= ua ^ ub;
        end
      end
    end
  end

  assign gcd  = b;
  assign coef = ub;

  assert_gcd_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |-> b[0]);
endmodule

// File: rtl/gf2_divider.sv
// Bit-serial polynomial long division, one quotient bit per clock.
module gf2_divider import invpoly_pkg::*; #(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] num,
  input  logic [K:0]   den,
  output logic         done,
  output logic [K-1:0] quo,
  output logic         exact
);
  localparam int IW = $clog2(K) + 1;

  logic          run;
  logic [IW-1:0] idx;
  logic [K-1:0]  rem;
  logic [K:0]    dreg;
  logic [2*K:0]  wide;
  logic [K-1:0]  qbit;
  logic          hit;
  int            dg, sh;

  always_comb begin
    dg   = top_bit(64'(dreg));
    sh   = int'(idx) - dg;
    hit  = (sh >= 0) && (dg >= 0) && rem[idx];
    wide = {{K{1'b0}}, dreg} << (hit ? sh : 0);
    qbit = {{(K-1){1'b0}}, 1'b1} << (hit ? sh : 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      rem  <= '0;
      quo  <= '0;
      dreg <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run  <= 1'b1;
        rem  <= num;
        quo  <= '0;
        dreg <= den;
        idx  <= IW'(K-1);
      end else if (run) begin
        if (hit) begin
          rem <= rem ^ wide[K-1:0];
          quo <= quo | qbit;
        end
        if (idx == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  assign exact = (rem == '0);

  assert_divisor_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start) |-> dreg != '0);
endmodule

// File: rtl/gf2_modmul.sv
// Horner multiply of x and y modulo C, one bit of x per clock.
module gf2_modmul #(
  parameter int K = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  input  logic [K-1:0] chr,
  output logic         done,
  output logic [K-1:0] prod
);
  localparam int IW = $clog2(K) + 1;

  logic          run;
  logic [IW-1:0] idx;
  logic [K-1:0]  acc, acc_nxt;

  always_comb begin
    acc_nxt = {acc[K-2:0], 1'b0} ^ (acc[K-1] ? chr : '0) ^ (x[idx] ? y : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      acc  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run <= 1'b1;
        acc <= '0;
        idx <= IW'(K-1);
      end else if (run) begin
        acc <= acc_nxt;
        if (idx == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx - 1'b1;
        end
      end
    end
  end

  assign prod = acc;

  assert_mul_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/invpoly_solver.sv
module invpoly_solver import invpoly_pkg::*; #(
  parameter int K  = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [K-1:0]  req_target,
  input  logic [LW-1:0] req_len,
  input  logic [K-1:0]  req_char,
  input  logic          req_inv0,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [K-1:0]  res_d,
  output logic          res_nosol
);
  phase_t        phase;
  logic          kick;
  logic [K-1:0]  tgt_q, atgt_q, chr_q;
  logic [LW-1:0] len_q;
  logic          inv0_q;

  logic          ones_done, gcd_done, div_done, div_exact, mul_done;
  logic [K-1:0]  bm, fm, coef, quo, prod;
  logic [K:0]    gcd;

  ones_mod_reducer #(.K(K), .LW(LW)) u_ones (
    .clk(clk), .rst_n(rst_n), .start(kick), .len(len_q), .chr(chr_q),
    .done(ones_done), .bm(bm), .fm(fm));

  binary_xgcd #(.K(K)) u_xgcd (
    .clk(clk), .rst_n(rst_n), .start(ones_done), .bin(bm), .chr(chr_q),
    .done(gcd_done), .gcd(gcd), .coef(coef));

  gf2_divider #(.K(K)) u_div (
    .clk(clk), .rst_n(rst_n), .start(gcd_done), .num(atgt_q), .den(gcd),
    .done(div_done), .quo(quo), .exact(div_exact));

  gf2_modmul #(.K(K)) u_mul (
    .clk(clk), .rst_n(rst_n), .start(div_done && div_exact), .x(quo), .y(coef),
    .chr(chr_q), .done(mul_done), .prod(prod));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      kick      <= 1'b0;
      tgt_q     <= '0;
      atgt_q    <= '0;
      chr_q     <= '0;
      len_q     <= '0;
      inv0_q    <= 1'b0;
      res_d     <= '0;
      res_nosol <= 1'b0;
    end else begin
      kick <= 1'b0;
      case (phase)
        PH_IDLE: if (req_valid) begin
          tgt_q  <= req_target;
          chr_q  <= req_char;
          len_q  <= req_len;
          inv0_q <= req_inv0;
          kick   <= 1'b1;
          phase  <= PH_ONES;
        end
        PH_ONES: if (ones_done) begin
          atgt_q <= tgt_q ^ (inv0_q ? fm : '0);
          phase  <= PH_GCD;
        end
        PH_GCD: if (gcd_done) phase <= PH_DIV;
        PH_DIV: if (div_done) begin
          if (div_exact) begin
            phase <= PH_MUL;
          end else begin
            res_d     <= '0;
            res_nosol <= 1'b1;
            phase     <= PH_OUT;
          end
        end
        PH_MUL: if (mul_done) begin
          res_d     <= prod;
          res_nosol <= 1'b0;
          phase     <= PH_OUT;
        end
        PH_OUT: if (res_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = (phase == PH_IDLE);
  assign res_valid = (phase == PH_OUT);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_d) && $stable(res_nosol)));

  assert_nosol_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_nosol) |-> res_d == '0);

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !res_valid));

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));
endmodule

// File: tb/invpoly_solver_test.sv
module invpoly_solver_test;
  localparam int K  = 4;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [K-1:0]  req_target = '0;
  logic [LW-1:0] req_len = '0;
  logic [K-1:0]  req_char = 4'b1001;
  logic          req_inv0 = 1'b0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [K-1:0]  res_d;
  logic          res_nosol;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  invpoly_solver #(.K(K), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_target(req_target), .req_len(req_len), .req_char(req_char),
    .req_inv0(req_inv0), .res_valid(res_valid), .res_ready(res_ready),
    .res_d(res_d), .res_nosol(res_nosol));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model of the signature recurrence s <- s*X + D + d0 (mod C)
  function automatic int mulx(int s, int c);
    int t;
    t = (s << 1) & 15;
    if ((s & 8) != 0) t = t ^ c;
    return t;
  endfunction

  function automatic int sig(int d, int l, int c, int inv);
    int s;
    s = d;
    for (int i = 0; i < l; i++) s = mulx(s, c) ^ d ^ inv;
    return s;
  endfunction

  function automatic bit solvable(int a, int l, int c, int inv);
    for (int d = 0; d < 16; d++) if (sig(d, l, c, inv) == a) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // per-clock protocol model: ready and valid never both high (R7)
  always @(negedge clk) begin
    if (rst_n && !finished) check(!(req_ready && res_valid), "R7 exclusive", req_ready, 0);
  end

  task automatic run_case(input int a, input int l, input int c, input int inv,
                          input int bp, input bit junk, output int gd, output bit gn);
    int wait_cyc;
    @(negedge clk);
    req_target = a[K-1:0];
    req_len    = l[LW-1:0];
    req_char   = c[K-1:0];
    req_inv0   = inv[0];
    req_valid  = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    check(req_ready == 1'b0, "R7 busy", req_ready, 0);
    if (junk) begin
      req_target = ~a[K-1:0];
      req_inv0   = ~inv[0];
      req_len    = 8'd3;
    end else begin
      req_valid = 1'b0;
    end
    wait_cyc = 1;
    while (!res_valid && wait_cyc < l + 6*K + 13) begin
      @(negedge clk);
      wait_cyc++;
      if (junk) check(req_ready == 1'b0, "R7 stray", req_ready, 0);
    end
    req_valid = 1'b0;
    check(res_valid == 1'b1, "R9 latency", wait_cyc, l + 6*K + 13);
    gd = int'(res_d);
    gn = res_nosol;
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      check(res_valid && res_d == gd[K-1:0] && res_nosol == gn, "R8 hold", res_d, gd);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(res_valid == 1'b0 && req_ready == 1'b1, "R7 release", res_valid, 0);
  endtask

  task automatic judge(input int a, input int l, input int c, input int inv,
                       input int gd, input bit gn);
    bit ex;
    ex = solvable(a, l, c, inv);
    check(gn == !ex, "R5 flag", gn, !ex);
    if (gn) check(gd == 0, "R5 zero", gd, 0);
    else if (inv == 0) check(sig(gd, l, c, 0) == a, "R3 equation", sig(gd, l, c, 0), a);
    else check(sig(gd, l, c, 1) == a, "R4 equation", sig(gd, l, c, 1), a);
  endtask

  initial begin
    int gd;
    bit gn;
    int cs[3];
    cs[0] = 9; cs[1] = 3; cs[2] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(res_valid == 1'b0, "R1 valid", res_valid, 0);

    run_case(13, 10, 9, 0, 2, 1'b0, gd, gn);
    check(gd == 5 && gn == 1'b0, "R2 reference", gd, 5);

    // R6: primitive C, L=14 folds B to zero; L=15 must solve
    for (int ci = 0; ci < 2; ci++) begin
      run_case(1, 14, cs[ci], 0, 0, 1'b0, gd, gn);
      check(gn == 1'b1, "R6 no-solution length", gn, 1);
      run_case(1, 15, cs[ci], 0, 1, 1'b0, gd, gn);
      check(gn == 1'b0, "R6 next length", gn, 0);
      judge(1, 15, cs[ci], 0, gd, gn);
    end

    for (int ci = 0; ci < 3; ci++)
      for (int l = 0; l < 16; l++)
        for (int a = 0; a < 16; a++)
          for (int inv = 0; inv < 2; inv++) begin
            run_case(a, l, cs[ci], inv, (a + l) % 3, (a % 5) == 0, gd, gn);
            judge(a, l, cs[ci], inv, gd, gn);
          end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule